// File: doc/BRIEF.md
# Configuration Window Register Decoder

This block keeps a small bank of 32-bit control words that describe a memory-mapped configuration window and several related address regions. Software reaches the words through a simple register port. The port decodes a run of 23 consecutive offsets that starts at a base offset fixed by a parameter. Every stored word reads back as it was written.

The configuration window is decoded in hardware. It has a 64-bit base, written as two 32-bit halves, and a 32-bit mask. Bit 0 of the mask turns the window on. The window size is the two's complement of the mask with bit 0 cleared, and that size is limited to a maximum set by a parameter. An incoming 64-bit address produces a hit flag and the offset of the address from the window base.

The register region has its own mask. The block reports the size that this mask encodes. The message region and the three outbound regions are only stored.

Top module: `cfgwin_regs`

## Requirements
- R1: Relative offsets have fixed meanings. 0 is the configuration base upper half and 1 is its lower half. 2 is the configuration mask. 3, 4 and 5 are the message base upper half, base lower half and mask. 6 to 17 cover three outbound regions of four words each, in the order base upper, base lower, mask upper, mask lower. 18 and 19 are the register-region base upper and lower halves, 20 is the register-region mask, 21 is a spare word and 22 is a control word. A read at any of these offsets returns the last value written there.
- R2: A write to a base half changes only that 32-bit half of the 64-bit base. The other half keeps its value.
- R3: `win_en` equals bit 0 of the configuration mask.
- R4: The unclamped size is `(~(mask & 32'hFFFF_FFFE) + 1)` taken modulo 2^32. A mask of 0 therefore gives size 0.
- R5: `win_size` is the unclamped size when that size does not exceed `MAX_WIN`, and `MAX_WIN` otherwise. For example, a mask of 0xE0000001 gives `MAX_WIN` when the default of 256 MiB is in use.
- R6: `regwin_size` is 4096 when the register-region mask equals 0x0000_7001. For any other mask value it follows the two's-complement rule of R4, without the clamp.
- R7: `win_hit` is 1 exactly when the window is enabled and base ≤ `win_addr` < base + `win_size`. The sum is taken without wrap-around, so a window that ends at 2^64 still hits at the top address.
- R8: `win_offset` equals `win_addr` − base, modulo 2^64.
- R9: Reset, which is asynchronous and active low, clears every word. After reset every read returns 0, the window is disabled and `win_hit` is 0.
- R10: A write outside the 23 decoded offsets changes no word, and a read outside them returns 0.
- R11: The word at relative offset k sits at port address `BLOCK_BASE + k`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, taken at the rising edge |
| reg_addr | input | ADDR_W | Register port address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| win_addr | input | 64 | Address to compare against the window |
| win_en | output | 1 | Window enable (configuration mask bit 0) |
| win_size | output | 32 | Clamped window size in bytes |
| win_hit | output | 1 | Address falls inside the enabled window |
| win_offset | output | 64 | Address minus window base |
| regwin_size | output | 32 | Size decoded from the register-region mask |

## Verification
The bench builds the block with `BLOCK_BASE` = 0x40 and `MAX_WIN` = 1 MiB. The nonzero base offset makes the first and last valid addresses, and the addresses just outside them, separate cases that can each be tested. The small maximum lets ordinary masks of a few megabytes hit the clamp, and a mask that encodes exactly 1 MiB tests the edge where the clamp does not yet apply. Random windows are also placed near the top of the 64-bit space, so a window that ends at 2^64 is tested.

// File: rtl/cfgwin_regs.sv
module cfgwin_regs #(
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned BLOCK_BASE = 'h100,
  parameter logic [31:0] MAX_WIN    = 32'h1000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [63:0]       win_addr,
  output logic              win_en,
  output logic [31:0]       win_size,
  output logic              win_hit,
  output logic [63:0]       win_offset,
  output logic [31:0]       regwin_size
);
  localparam int unsigned NREG  = 23;
  localparam int unsigned OFS_W = $clog2(NREG);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BLOCK_BASE);
  localparam int unsigned I_CBH = 0, I_CBL = 1, I_CMSK = 2, I_RMSK = 20;

  logic [31:0] regs [NREG];

  logic [ADDR_W-1:0] rel;
  logic              in_rng;
  logic [OFS_W-1:0]  idx;

  assign rel    = reg_addr - BASE_A;
  assign in_rng = (reg_addr >= BASE_A) && (rel < ADDR_W'(NREG));
  assign idx    = rel[OFS_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (reg_wr && in_rng) begin
      regs[idx] <= reg_wdata;
    end
  end

  assign reg_rdata = in_rng ? regs[idx] : 32'd0;

  logic [63:0] cfg_base;
  logic [31:0] cfg_mask, raw_size, rmask;
  logic [64:0] win_end;

  assign cfg_base = {regs[I_CBH], regs[I_CBL]};
  assign cfg_mask = regs[I_CMSK];
  assign raw_size = ~(cfg_mask & 32'hFFFF_FFFE) + 32'd1;
  assign win_en   = cfg_mask[0];
  assign win_size = (raw_size > MAX_WIN) ? MAX_WIN : raw_size;
  assign win_end  = {1'b0, cfg_base} + {33'd0, win_size};
  assign win_hit  = win_en && (win_addr >= cfg_base) && ({1'b0, win_addr} < win_end);
  assign win_offset = win_addr - cfg_base;

  assign rmask       = regs[I_RMSK];
  assign regwin_size = (rmask == 32'h0000_7001) ? 32'd4096
                                                : ~(rmask & 32'hFFFF_FFFE) + 32'd1;
endmodule

module cfgwin_regs_chk #(
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned BLOCK_BASE = 'h100,
  parameter logic [31:0] MAX_WIN    = 32'h1000_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic              win_en,
  input logic [31:0]       win_size,
  input logic              win_hit,
  input logic [63:0]       win_offset
);
  logic decoded;
  assign decoded = (int'(reg_addr) >= int'(BLOCK_BASE)) && (int'(reg_addr) < int'(BLOCK_BASE) + 23);

  p_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && decoded) |=> (reg_wr || reg_addr != $past(reg_addr) || reg_rdata == $past(reg_wdata)));

  p_hit_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> win_en);

  p_size_clamped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    win_size <= MAX_WIN);

  p_offset_inside_r8: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> (win_offset < {32'd0, win_size}));

  p_reset_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!win_en && !win_hit && reg_rdata == 32'd0));
endmodule

bind cfgwin_regs cfgwin_regs_chk #(.ADDR_W(ADDR_W), .BLOCK_BASE(BLOCK_BASE), .MAX_WIN(MAX_WIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .win_en(win_en),
  .win_size(win_size), .win_hit(win_hit), .win_offset(win_offset)
);

// File: tb/tb_cfgwin_regs.sv
module tb_cfgwin_regs;
  localparam int CLK_P = 10;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned BB = 'h40;
  localparam logic [31:0] MAXW = 32'h0010_0000;

  logic clk = 0, rst_n = 0, reg_wr = 0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, win_size, regwin_size;
  logic [63:0] win_addr = '0, win_offset;
  logic win_en, win_hit;

  int checks = 0, fails = 0;
  logic [31:0] mdl [23];
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  cfgwin_regs #(.ADDR_W(ADDR_W), .BLOCK_BASE(BB), .MAX_WIN(MAXW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .win_addr(win_addr),
    .win_en(win_en), .win_size(win_size), .win_hit(win_hit),
    .win_offset(win_offset), .regwin_size(regwin_size));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] f_raw(input logic [31:0] m);
    return ~(m & 32'hFFFF_FFFE) + 32'd1;
  endfunction
  function automatic logic [31:0] f_size(input logic [31:0] m);
    return (f_raw(m) > MAXW) ? MAXW : f_raw(m);
  endfunction
  function automatic logic [31:0] f_rsize(input logic [31:0] m);
    return (m == 32'h7001) ? 32'd4096 : f_raw(m);
  endfunction
  function automatic bit f_hit(input logic [63:0] b, input logic [31:0] m, input logic [63:0] a);
    logic [64:0] e;
    e = {1'b0, b} + {33'd0, f_size(m)};
    return m[0] && a >= b && {1'b0, a} < e;
  endfunction

  task automatic wr(input int ofs, input logic [31:0] v);
    @(negedge clk);
    reg_wr = 1; reg_addr = ADDR_W'(int'(BB) + ofs); reg_wdata = v;
    @(negedge clk);
    reg_wr = 0;
    if (ofs >= 0 && ofs < 23) mdl[ofs] = v;
  endtask

  task automatic rd(input int ofs, output logic [31:0] v);
    reg_addr = ADDR_W'(int'(BB) + ofs);
    #1 v = reg_rdata;
  endtask

  task automatic check_all(input string req);
    logic [31:0] v;
    for (int k = 0; k < 23; k++) begin
      rd(k, v);
      chk(v == mdl[k], req, v, mdl[k]);
    end
  endtask

  task automatic check_win(input logic [63:0] a, input string req);
    logic [63:0] b;
    b = {mdl[0], mdl[1]};
    win_addr = a;
    #1;
    chk(win_en == mdl[2][0], "R3", win_en, mdl[2][0]);
    chk(win_size == f_size(mdl[2]), req, win_size, f_size(mdl[2]));
    chk(win_hit == f_hit(b, mdl[2], a), "R7", win_hit, f_hit(b, mdl[2], a));
    chk(win_offset == a - b, "R8", win_offset, a - b);
  endtask

  task automatic set_win(input logic [63:0] b, input logic [31:0] m);
    wr(0, b[63:32]); wr(1, b[31:0]); wr(2, m);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [63:0] b, a;
    logic [31:0] m;
    void'($urandom(32'h5EED));
    for (int k = 0; k < 23; k++) mdl[k] = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check_all("R9");
    chk(win_en == 0 && win_hit == 0, "R9", {win_en, win_hit}, 0);
    rst_n = 1;
    // R1, R11: every word reads back
    for (int k = 0; k < 23; k++) wr(k, $urandom);
    check_all("R1_R11");
    // R2: halves
    wr(0, 32'hAAAA_0001); wr(1, 32'h5555_0002); wr(0, 32'h1234_5678);
    rd(1, v); chk(v == 32'h5555_0002, "R2", v, 32'h5555_0002);
    wr(19, 32'hCAFE_0000); rd(18, v); chk(v == mdl[18], "R2", v, mdl[18]);
    // R10: outside range
    wr(-1, 32'hDEAD_BEEF); wr(23, 32'hFEED_F00D);
    rd(-1, v); chk(v == 0, "R10", v, 0);
    rd(23, v); chk(v == 0, "R10", v, 0);
    check_all("R10");
    // R3/R4/R5 directed masks
    set_win(64'h0000_0001_0000_0000, 32'hFFFF_F000);
    check_win(64'h0000_0001_0000_0010, "R3");
    set_win(64'h0000_0001_0000_0000, 32'hFFFF_F001);
    check_win(64'h0000_0001_0000_0FFF, "R4");
    check_win(64'h0000_0001_0000_1000, "R4");
    check_win(64'h0000_0000_FFFF_FFFF, "R7");
    check_win(64'h0000_0001_0000_0000, "R7");
    set_win(64'h0000_0001_0000_0000, 32'hE000_0001);
    check_win(64'h0000_0001_000F_FFFF, "R5");
    check_win(64'h0000_0001_0010_0000, "R5");
    set_win(64'h0000_0001_0000_0000, 32'hFFF0_0001);
    check_win(64'h0000_0001_000F_FFFF, "R5");
    set_win(64'h0000_0001_0000_0000, 32'hFFE0_0001);
    check_win(64'h0000_0001_0010_0000, "R5");
    set_win(64'h0000_0001_0000_0000, 32'h0000_0001);
    check_win(64'h0000_0001_0000_0000, "R4");
    // window ending at 2^64
    set_win(64'hFFFF_FFFF_FFFF_F000, 32'hFFFF_F001);
    check_win(64'hFFFF_FFFF_FFFF_FFFF, "R7");
    check_win(64'hFFFF_FFFF_FFFF_EFFF, "R7");
    // R6
    wr(20, 32'h0000_7001); #1 chk(regwin_size == 4096, "R6", regwin_size, 4096);
    wr(20, 32'hFFFF_0000); #1 chk(regwin_size == f_rsize(32'hFFFF_0000), "R6", regwin_size, f_rsize(32'hFFFF_0000));
    wr(20, 32'hE000_0001); #1 chk(regwin_size == 32'h2000_0000, "R6", regwin_size, 32'h2000_0000);
    // random windows
    for (int n = 0; n < 150; n++) begin
      b = {$urandom, $urandom};
      if (n % 5 == 0) b = {32'hFFFF_FFFF, $urandom};
      if (n % 3 == 0) m = $urandom;
      else m = ~((32'd1 << ($urandom % 25)) - 32'd1) | {31'd0, 1'($urandom)};
      set_win(b, m);
      a = b + 64'($signed(32'($urandom % 32'h0030_0000)) - 32'sh0000_8000);
      check_win(a, "R4_R5");
      v = $urandom;
      wr(20, v); #1 chk(regwin_size == f_rsize(v), "R6", regwin_size, f_rsize(v));
    end
    check_all("R1");
    // R9 again: reset mid-run
    @(negedge clk); rst_n = 0;
    for (int k = 0; k < 23; k++) mdl[k] = '0;
    #1 check_all("R9");
    chk(win_en == 0 && win_hit == 0, "R9", {win_en, win_hit}, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule